// File: doc/BRIEF.md
# LCD Controller Register and Interrupt Unit

This block is the software-visible register file of a simple LCD controller. A 32-bit bus with byte offsets reaches six registers: control, three panel timing words, a read-only status word and a subpanel word. The block decodes the control word into the mode fields used by the rest of the controller. It keeps three sticky status flags (frame finished, palette loaded, sync fault) and drives one level interrupt from those flags and two enable bits.

Writing the enable bit with a new value starts or stops the controller, and each of those edges updates the flags in a fixed way. Two single-cycle event inputs come from the frame-fetch side. One reports that the palette has been loaded and the other reports a sync fault. Each event sets its own flag.

Top module: `lcd_regif`

## Requirements
- R1: Registers sit at byte offsets 0x00 control, 0x04 timing0, 0x08 timing1, 0x0C timing2, 0x10 status and 0x14 subpanel. Any other offset reads 0 and ignores writes. Read data is registered: it appears on the clock edge that samples `bus_rd`, and it holds its value while `bus_rd` is low.
- R2: A control write stores the load mode from bits 21:20, the TFT flag from bit 7, the interrupt enables from bits 4:3, mono from bit 1, enable from bit 0, and the write data ANDed with 0x01CFF300. A control read returns these fields in the same positions, with TFT repeated at bit 23, ORed with the masked bits and with 0xFE000C34.
- R3: A timing0 or timing1 write sets the panel width (timing0) or height (timing1) to bits 9:0 plus one, and keeps bits 31:10. A read returns the kept bits at 31:10 and the low 10 bits of the dimension minus one at 9:0. A timing0 read also ORs in 0xF, so after reset timing0 reads 0x3FF and timing1 reads 0x3FF.
- R4: Timing2 keeps the whole written word and reads back ORed with 0xFC000000. Subpanel keeps the written word ANDed with 0xA1FFFFFF.
- R5: Status reads return palette-loaded at bit 6, sync-fault at bit 2 and frame-finished at bit 0, with all other bits 0. Writes to status change nothing.
- R6: `lcd_irq` is registered. One cycle after the flags are in a given state, it is high when frame-finished is set with enable bit 3, when palette-loaded is set with enable bit 4, or when sync-fault is set, whatever the enables hold.
- R7: A control write that moves enable from 1 to 0 clears sync-fault. It sets frame-finished unless the newly written load mode equals 1, in which case frame-finished keeps its value.
- R8: A control write that moves enable from 0 to 1 clears frame-finished and palette-loaded. This clearing wins over a palette event in the same cycle.
- R9: A control write that leaves enable unchanged starts no sequence and leaves all flags as they were.
- R10: A `pal_loaded` pulse sets palette-loaded and a `sync_fault` pulse sets sync-fault. Both flags stay set until a start or stop sequence clears them.
- R11: Synchronous reset sets every field, flag, dimension, `bus_rdata` and `lcd_irq` to zero.
- R12: The outputs `ctl_enable`, `ctl_load_mode`, `ctl_tft`, `ctl_mono`, `panel_width` and `panel_height` show the stored fields one cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pal_loaded | input | 1 | Palette-loaded event pulse |
| sync_fault | input | 1 | Sync-fault event pulse |
| lcd_irq | output | 1 | Level interrupt, registered |
| ctl_enable | output | 1 | Stored enable bit |
| ctl_load_mode | output | 2 | Stored load mode |
| ctl_tft | output | 1 | Stored TFT flag |
| ctl_mono | output | 1 | Stored mono flag |
| panel_width | output | DIM_W+1 | Width (field plus one) |
| panel_height | output | DIM_W+1 | Height (field plus one) |

## Verification
A write or an event pulse changes the fields and flags on the edge that samples it. A status read issued in the next cycle therefore shows the new flags one edge later. `lcd_irq` follows the flags one edge after they change, which is the same edge on which that status read data lands. The bench drives on falling edges and issues every read after the write or pulse has been taken. It samples data and interrupt on the falling edge that follows the read edge, so both results are due by the time it looks.

// File: rtl/lcd_regif_pkg.sv
package lcd_regif_pkg;

  localparam int DATA_W = 32;

  localparam int unsigned OFS_CTRL = 32'h00;
  localparam int unsigned OFS_TIM0 = 32'h04;
  localparam int unsigned OFS_TIM1 = 32'h08;
  localparam int unsigned OFS_TIM2 = 32'h0C;
  localparam int unsigned OFS_STAT = 32'h10;
  localparam int unsigned OFS_SUB  = 32'h14;

  localparam logic [DATA_W-1:0] CTRL_KEEP = 32'h01CF_F300;
  localparam logic [DATA_W-1:0] CTRL_SET  = 32'hFE00_0C34;
  localparam logic [DATA_W-1:0] TIM0_SET  = 32'h0000_000F;
  localparam logic [DATA_W-1:0] TIM2_SET  = 32'hFC00_0000;
  localparam logic [DATA_W-1:0] SUB_KEEP  = 32'hA1FF_FFFF;

  localparam int POS_EN    = 0;
  localparam int POS_MONO  = 1;
  localparam int POS_IEN   = 3;
  localparam int POS_TFT   = 7;
  localparam int POS_LM    = 20;
  localparam int POS_TFT2  = 23;
  localparam int POS_SFD   = 0;
  localparam int POS_SSE   = 2;
  localparam int POS_SPD   = 6;

  localparam logic [1:0] LM_NO_FRAME = 2'd1;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTRL, SEL_TIM0, SEL_TIM1, SEL_TIM2, SEL_STAT, SEL_SUB
  } sel_e;

  typedef struct packed {
    logic [1:0]        load_mode;
    logic              tft;
    logic [1:0]        ien;
    logic              mono;
    logic              en;
    logic [DATA_W-1:0] misc;
  } ctrl_t;

  typedef struct packed {
    logic frame_done;
    logic pal_done;
    logic sync_err;
  } flags_t;

  function automatic sel_e decode_ofs(input logic [31:0] ofs);
    case (ofs)
      OFS_CTRL: decode_ofs = SEL_CTRL;
      OFS_TIM0: decode_ofs = SEL_TIM0;
      OFS_TIM1: decode_ofs = SEL_TIM1;
      OFS_TIM2: decode_ofs = SEL_TIM2;
      OFS_STAT: decode_ofs = SEL_STAT;
      OFS_SUB:  decode_ofs = SEL_SUB;
      default:  decode_ofs = SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/lcd_regif_store.sv
module lcd_regif_store
  import lcd_regif_pkg::*;
#(
  parameter int DIM_W = 10,
  localparam int HI_W = DATA_W - DIM_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  sel_e                sel,
  input  logic [DATA_W-1:0]   wdata,
  output ctrl_t               ctrl,
  output logic [HI_W-1:0]     tim_hi [2],
  output logic [DIM_W:0]      dim    [2],
  output logic [DATA_W-1:0]   tim2,
  output logic [DATA_W-1:0]   sub,
  output logic                en_on,
  output logic                en_off
);

  logic wr_ctrl;
  logic wr_tim [2];

  assign wr_ctrl   = wr_en && (sel == SEL_CTRL);
  assign wr_tim[0] = wr_en && (sel == SEL_TIM0);
  assign wr_tim[1] = wr_en && (sel == SEL_TIM1);

  // start and stop strobes: a control write that flips the enable bit
  assign en_on  = wr_ctrl &&  wdata[POS_EN] && !ctrl.en;
  assign en_off = wr_ctrl && !wdata[POS_EN] &&  ctrl.en;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else if (wr_ctrl) begin
      ctrl.load_mode <= wdata[POS_LM +: 2];
      ctrl.tft       <= wdata[POS_TFT];
      ctrl.ien       <= wdata[POS_IEN +: 2];
      ctrl.mono      <= wdata[POS_MONO];
      ctrl.en        <= wdata[POS_EN];
      ctrl.misc      <= wdata & CTRL_KEEP;
    end
  end

  // the two dimension registers share one layout
  for (genvar g = 0; g < 2; g++) begin : g_tim
    always_ff @(posedge clk) begin
      if (rst) begin
        tim_hi[g] <= '0;
        dim[g]    <= '0;
      end else if (wr_tim[g]) begin
        tim_hi[g] <= wdata[DATA_W-1:DIM_W];
        dim[g]    <= {1'b0, wdata[DIM_W-1:0]} + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tim2 <= '0;
      sub  <= '0;
    end else if (wr_en) begin
      if (sel == SEL_TIM2) tim2 <= wdata;
      if (sel == SEL_SUB)  sub  <= wdata & SUB_KEEP;
    end
  end

endmodule

// File: rtl/lcd_regif_flags.sv
module lcd_regif_flags
  import lcd_regif_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en_on,
  input  logic       en_off,
  input  logic [1:0] new_lm,
  input  logic       pal_evt,
  input  logic       sync_evt,
  output flags_t     flags
);

  // later statements win: the start/stop sequence overrides same-cycle events
  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
    end else begin
      if (pal_evt)  flags.pal_done <= 1'b1;
      if (sync_evt) flags.sync_err <= 1'b1;
      if (en_on) begin
        flags.frame_done <= 1'b0;
        flags.pal_done   <= 1'b0;
      end
      if (en_off) begin
        flags.sync_err <= 1'b0;
        if (new_lm != LM_NO_FRAME) flags.frame_done <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/lcd_regif_irq.sv
module lcd_regif_irq
  import lcd_regif_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  flags_t     flags,
  input  logic [1:0] ien,
  output logic       irq
);

  logic irq_next;

  assign irq_next = (flags.frame_done && ien[0]) ||
                    (flags.pal_done   && ien[1]) ||
                    flags.sync_err;

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= irq_next;
  end

endmodule

// File: rtl/lcd_regif_rdmux.sv
module lcd_regif_rdmux
  import lcd_regif_pkg::*;
#(
  parameter int DIM_W = 10,
  localparam int HI_W = DATA_W - DIM_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_en,
  input  sel_e                sel,
  input  ctrl_t               ctrl,
  input  logic [HI_W-1:0]     tim_hi [2],
  input  logic [DIM_W:0]      dim    [2],
  input  logic [DATA_W-1:0]   tim2,
  input  logic [DATA_W-1:0]   sub,
  input  flags_t              flags,
  output logic [DATA_W-1:0]   rdata
);

  logic [DATA_W-1:0] ctrl_word;
  logic [DATA_W-1:0] stat_word;
  logic [DATA_W-1:0] tim_word [2];
  logic [DATA_W-1:0] word;

  always_comb begin
    ctrl_word = CTRL_SET | ctrl.misc;
    ctrl_word[POS_TFT2]    = ctrl.tft;
    ctrl_word[POS_LM +: 2] = ctrl.load_mode;
    ctrl_word[POS_TFT]     = ctrl.tft;
    ctrl_word[POS_IEN +: 2] = ctrl.ien;
    ctrl_word[POS_MONO]    = ctrl.mono;
    ctrl_word[POS_EN]      = ctrl.en;
    // constant and masked bits may overlap field positions; OR them back in
    ctrl_word = ctrl_word | CTRL_SET | ctrl.misc;
  end

  always_comb begin
    stat_word = '0;
    stat_word[POS_SPD] = flags.pal_done;
    stat_word[POS_SSE] = flags.sync_err;
    stat_word[POS_SFD] = flags.frame_done;
  end

  for (genvar g = 0; g < 2; g++) begin : g_tw
    logic [DIM_W:0] dm1;
    assign dm1         = dim[g] - 1'b1;
    assign tim_word[g] = {tim_hi[g], dm1[DIM_W-1:0]};
  end

  always_comb begin
    case (sel)
      SEL_CTRL: word = ctrl_word;
      SEL_TIM0: word = tim_word[0] | TIM0_SET;
      SEL_TIM1: word = tim_word[1];
      SEL_TIM2: word = tim2 | TIM2_SET;
      SEL_STAT: word = stat_word;
      SEL_SUB:  word = sub;
      default:  word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= word;
  end

endmodule

// File: rtl/lcd_regif.sv
module lcd_regif
  import lcd_regif_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DIM_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              pal_loaded,
  input  logic              sync_fault,
  output logic              lcd_irq,
  output logic              ctl_enable,
  output logic [1:0]        ctl_load_mode,
  output logic              ctl_tft,
  output logic              ctl_mono,
  output logic [DIM_W:0]    panel_width,
  output logic [DIM_W:0]    panel_height
);

  localparam int HI_W = DATA_W - DIM_W;

  sel_e              sel;
  ctrl_t             ctrl;
  logic [HI_W-1:0]   tim_hi [2];
  logic [DIM_W:0]    dim    [2];
  logic [DATA_W-1:0] tim2;
  logic [DATA_W-1:0] sub;
  logic              en_on;
  logic              en_off;
  flags_t            flags;

  assign sel = decode_ofs(32'(bus_addr));

  lcd_regif_store #(.DIM_W(DIM_W)) u_store (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .sel(sel), .wdata(bus_wdata),
    .ctrl(ctrl), .tim_hi(tim_hi), .dim(dim), .tim2(tim2), .sub(sub),
    .en_on(en_on), .en_off(en_off)
  );

  lcd_regif_flags u_flags (
    .clk(clk), .rst(rst), .en_on(en_on), .en_off(en_off),
    .new_lm(bus_wdata[POS_LM +: 2]), .pal_evt(pal_loaded),
    .sync_evt(sync_fault), .flags(flags)
  );

  lcd_regif_irq u_irq (
    .clk(clk), .rst(rst), .flags(flags), .ien(ctrl.ien), .irq(lcd_irq)
  );

  lcd_regif_rdmux #(.DIM_W(DIM_W)) u_rdmux (
    .clk(clk), .rst(rst), .rd_en(bus_rd), .sel(sel), .ctrl(ctrl),
    .tim_hi(tim_hi), .dim(dim), .tim2(tim2), .sub(sub), .flags(flags),
    .rdata(bus_rdata)
  );

  assign ctl_enable    = ctrl.en;
  assign ctl_load_mode = ctrl.load_mode;
  assign ctl_tft       = ctrl.tft;
  assign ctl_mono      = ctrl.mono;
  assign panel_width   = dim[0];
  assign panel_height  = dim[1];

endmodule

// File: rtl/lcd_regif_chk.sv
module lcd_regif_chk
  import lcd_regif_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       en_on,
  input logic       en_off,
  input logic [1:0] new_lm,
  input logic       pal_evt,
  input logic       sync_evt,
  input flags_t     flags,
  input logic [1:0] ien,
  input logic       irq
);

  // R6
  irq_follows_flags_chk: assert property (@(posedge clk) disable iff (rst)
    irq == $past((flags.frame_done && ien[0]) || (flags.pal_done && ien[1]) || flags.sync_err));

  // R8
  start_clears_chk: assert property (@(posedge clk) disable iff (rst)
    en_on |=> (!flags.frame_done && !flags.pal_done));

  // R7
  stop_clears_sync_chk: assert property (@(posedge clk) disable iff (rst)
    en_off |=> !flags.sync_err);

  // R7
  stop_sets_frame_chk: assert property (@(posedge clk) disable iff (rst)
    (en_off && new_lm != LM_NO_FRAME) |=> flags.frame_done);

  // R7
  stop_keeps_frame_chk: assert property (@(posedge clk) disable iff (rst)
    (en_off && new_lm == LM_NO_FRAME) |=> $stable(flags.frame_done));

  // R10
  sync_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (sync_evt && !en_off) |=> flags.sync_err);

  // R10
  pal_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (pal_evt && !en_on) |=> flags.pal_done);

  // R5
  flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!pal_evt && !sync_evt && !en_on && !en_off) |=> $stable(flags));

  // R11
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!irq && flags == '0));

endmodule

bind lcd_regif lcd_regif_chk u_chk (
  .clk(clk), .rst(rst), .en_on(en_on), .en_off(en_off),
  .new_lm(bus_wdata[lcd_regif_pkg::POS_LM +: 2]), .pal_evt(pal_loaded),
  .sync_evt(sync_fault), .flags(flags), .ien(ctrl.ien), .irq(lcd_irq)
);

// File: tb/lcd_regif_test.sv
`timescale 1ns/1ps
module lcd_regif_test;

  localparam int ADDR_W = 8;
  localparam int DIM_W  = 10;
  localparam int NVEC   = 8;

  // {offset, write data, expected readback}
  localparam logic [71:0] VEC [NVEC] = '{
    {8'h04, 32'hABCD_E123, 32'hABCD_E12F},
    {8'h08, 32'h0000_07FF, 32'h0000_07FF},
    {8'h0C, 32'h0123_4567, 32'hFD23_4567},
    {8'h14, 32'hFFFF_FFFF, 32'hA1FF_FFFF},
    {8'h18, 32'hFFFF_FFFF, 32'h0000_0000},
    {8'h10, 32'hFFFF_FFFF, 32'h0000_0000},
    {8'h00, 32'hFFFF_FFFE, 32'hFFFF_FFBE},
    {8'h00, 32'h0000_0000, 32'hFE00_0C34}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              pal_loaded = 1'b0;
  logic              sync_fault = 1'b0;
  logic              lcd_irq;
  logic              ctl_enable;
  logic [1:0]        ctl_load_mode;
  logic              ctl_tft;
  logic              ctl_mono;
  logic [DIM_W:0]    panel_width;
  logic [DIM_W:0]    panel_height;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  lcd_regif #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pal_loaded(pal_loaded), .sync_fault(sync_fault), .lcd_irq(lcd_irq),
    .ctl_enable(ctl_enable), .ctl_load_mode(ctl_load_mode),
    .ctl_tft(ctl_tft), .ctl_mono(ctl_mono),
    .panel_width(panel_width), .panel_height(panel_height)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic pal = 1'b0);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; pal_loaded = pal;
    @(negedge clk);
    bus_wr = 1'b0; pal_loaded = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(input bit is_sync);
    @(negedge clk);
    if (is_sync) sync_fault = 1'b1; else pal_loaded = 1'b1;
    @(negedge clk);
    sync_fault = 1'b0; pal_loaded = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic check_status(input string req, input logic [31:0] exp_st, input logic exp_irq);
    logic [31:0] st;
    bus_read(8'h10, st);
    check(req, st, exp_st);
    check(req, 32'(lcd_irq), 32'(exp_irq));
  endtask

  task automatic check_reset_values(input string req);
    logic [31:0] v;
    bus_read(8'h00, v); check(req, v, 32'hFE00_0C34);
    bus_read(8'h04, v); check(req, v, 32'h0000_03FF);
    bus_read(8'h08, v); check(req, v, 32'h0000_03FF);
    bus_read(8'h0C, v); check(req, v, 32'hFC00_0000);
    bus_read(8'h10, v); check(req, v, 32'h0000_0000);
    bus_read(8'h14, v); check(req, v, 32'h0000_0000);
    check(req, 32'(lcd_irq), 32'h0);
    check(req, 32'(panel_width), 32'h0);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(" R11 rdata after reset", bus_rdata, 32'h0);
    check_reset_values("R11 R3 reset readback");

    // R1 R2 R3 R4 R5: table walk, write then read each entry
    for (int i = 0; i < NVEC; i++) begin
      bus_write(VEC[i][71:64], VEC[i][63:32]);
      bus_read(VEC[i][71:64], v);
      check($sformatf("R1 R2 R3 R4 R5 vector %0d", i), v, VEC[i][31:0]);
    end

    // R12 decoded dimensions from the table writes
    check("R12 width", 32'(panel_width), 32'h124);
    check("R12 height", 32'(panel_height), 32'h400);
    bus_write(8'h00, 32'h0020_0082);
    check("R12 load mode", 32'(ctl_load_mode), 32'h2);
    check("R12 tft", 32'(ctl_tft), 32'h1);
    check("R12 mono", 32'(ctl_mono), 32'h1);
    check("R12 enable", 32'(ctl_enable), 32'h0);
    bus_write(8'h00, 32'h0);

    // R8: start with both enables
    bus_write(8'h00, 32'h0000_0019);
    check("R12 enable set", 32'(ctl_enable), 32'h1);
    check_status("R8 start", 32'h0, 1'b0);
    // R10 palette event, R6 enabled source
    pulse(1'b0);
    check_status("R10 R6 palette", 32'h40, 1'b1);
    // R7 stop with load mode 0
    bus_write(8'h00, 32'h0000_0018);
    check_status("R7 stop sets frame", 32'h41, 1'b1);
    // R8 restart with enables off
    bus_write(8'h00, 32'h0000_0001);
    check_status("R8 restart clears", 32'h0, 1'b0);
    // R6 sync fault cannot be masked
    pulse(1'b1);
    check_status("R6 R10 sync unmasked", 32'h04, 1'b1);
    // R5 status write ignored
    bus_write(8'h10, 32'hFFFF_FFFF);
    check_status("R5 status write", 32'h04, 1'b1);
    // R7 stop with load mode 1: no frame flag, sync cleared
    bus_write(8'h00, 32'h0010_0000);
    check_status("R7 stop mode1", 32'h0, 1'b0);
    // R6 masked frame flag
    bus_write(8'h00, 32'h0000_0001);
    bus_write(8'h00, 32'h0000_0000);
    check_status("R6 frame masked", 32'h01, 1'b0);
    // R9 enable unchanged: no sequence, R6 now enabled
    bus_write(8'h00, 32'h0000_0008);
    check_status("R9 R6 no sequence", 32'h01, 1'b1);
    // R8 start wins over same-cycle palette event
    bus_write(8'h00, 32'h0000_0011, 1'b1);
    check_status("R8 start beats event", 32'h0, 1'b0);

    // R1 read data holds while no read
    bus_read(8'h0C, v);
    bus_write(8'h0C, 32'h0000_0000);
    @(negedge clk);
    check("R1 rdata hold", bus_rdata, 32'hFD23_4567);
    bus_read(8'h0C, v);
    check("R4 timing2 new", v, 32'hFC00_0000);

    // R11 reset mid-run with flags set
    pulse(1'b1);
    do_reset();
    check_reset_values("R11 mid-run reset");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule